// File: doc/BRIEF.md
# VLIW Molecule Slot Dispatcher

This block sits after instruction fetch in a very-long-instruction-word core. Each cycle it can accept one fetched instruction word, called a molecule. A molecule is either short (64 bits, two 32-bit operation slots) or long (128 bits, four slots). Molecule bit 0 selects the length. The block cuts the word into its slots. Each slot's operation, called an atom, goes to a functional unit chosen only by the slot's position and the format. No dependency analysis or reordering takes place. The five units are two integer units, one floating-point unit, one load/store unit and one branch unit.

All atoms of a molecule appear together on the registered per-unit outputs one cycle after the molecule is accepted. Molecules leave in the order they arrive. For each atom the block splits out these fields:
- the opcode,
- the condition-code update flag,
- the destination register specifier (6 bits, 64-entry integer file),
- two source register specifiers,
- a small immediate.

An all-zero opcode is a no-op and issues to nothing. A stall input freezes the outputs and drops the incoming word.

Top module: `vliw_dispatch`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle, whatever is presented on the inputs.
- R2: `mol_data[0]` = 0 marks a short molecule; only slots 0 and 1 (bits 63:0) are used and bits 127:64 have no effect on any output. `mol_data[0]` = 1 marks a long molecule using all four slots. `issue_long` shows the format of the molecule on the outputs (0 during a bubble).
- R3: Long molecule routing: slot 0 (bits 31:0) to integer unit 0, slot 1 (bits 63:32) to the floating-point unit, slot 2 (bits 95:64) to the load/store unit, slot 3 (bits 127:96) to the branch unit; integer unit 1 stays idle.
- R4: Short molecule routing: slot 0 to integer unit 0, slot 1 to integer unit 1; floating-point, load/store and branch units stay idle.
- R5: A slot whose opcode field (atom bits 31:26) is zero is a no-op: its unit's valid bit is low and all its fields read zero. The same holds for every unit that receives no slot.
- R6: For a valid unit, the fields are taken from the atom as follows: opcode = bits 31:26, destination = bits 24:19, source A = bits 18:13, source B = bits 12:7, immediate = bits 6:0.
- R7: Atom bit 25 is the condition-code update flag and appears on the unit's `u_cc` bit when the slot is valid.
- R8: Every valid atom of a molecule is presented in the same cycle, one cycle after the molecule is accepted, and back-to-back molecules appear in input order with no gap.
- R9: While `stall` is high, all outputs keep their values and the molecule presented in that cycle is discarded.
- R10: A cycle with `stall` low and `mol_vld` low produces a bubble: all valid bits and fields go to zero on the next cycle.

Unit index order in all per-unit vectors: 0 = integer 0, 1 = integer 1, 2 = floating point, 3 = load/store, 4 = branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold outputs and refuse the incoming molecule |
| mol_vld | input | 1 | A molecule is present on `mol_data` |
| mol_data | input | 128 | Fetched molecule; bit 0 selects the format |
| issue_long | output | 1 | Format of the issued molecule (1 = long) |
| u_vld | output | 5 | Per-unit atom valid |
| u_op | output | 30 | Per-unit opcode, 6 bits per unit |
| u_cc | output | 5 | Per-unit condition-code update flag |
| u_dst | output | 30 | Per-unit destination register, 6 bits per unit |
| u_sa | output | 30 | Per-unit source A register, 6 bits per unit |
| u_sb | output | 30 | Per-unit source B register, 6 bits per unit |
| u_imm | output | 35 | Per-unit immediate, 7 bits per unit |

## Verification
The bench checks that short molecules with random bits 127:64 produce no output in those bits. A decoder that ignored the format bit would push stray atoms into the floating-point, load/store or branch units. It checks that slot 1 lands on the floating-point unit in long format and on integer unit 1 in short format. Swapping that mapping would send one atom to two units or to the wrong one. Molecules with zero opcodes in chosen slots catch a design that raises valid for no-ops or leaves stale fields behind. It presents a new molecule during a stall to catch a design that loads it or clears the outputs. It inserts a bubble to catch a design that repeats the last molecule.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int ATOM_W      = 32;
  localparam int MAX_SLOTS   = 4;
  localparam int SHORT_SLOTS = 2;
  localparam int MOL_W       = ATOM_W * MAX_SLOTS;
  localparam int NUM_REGS    = 64;
  localparam int REG_W       = $clog2(NUM_REGS);
  localparam int OP_W        = 6;
  localparam int IMM_W       = ATOM_W - OP_W - 1 - 3 * REG_W;
  localparam int NUM_UNITS   = 5;
  localparam int UNIT_W      = $clog2(NUM_UNITS);
  localparam int FMT_BIT     = 0;

  localparam logic [UNIT_W-1:0] UNIT_INT0 = 3'd0;
  localparam logic [UNIT_W-1:0] UNIT_INT1 = 3'd1;
  localparam logic [UNIT_W-1:0] UNIT_FPU  = 3'd2;
  localparam logic [UNIT_W-1:0] UNIT_LSU  = 3'd3;
  localparam logic [UNIT_W-1:0] UNIT_BRU  = 3'd4;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             cc;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] sa;
    logic [REG_W-1:0] sb;
    logic [IMM_W-1:0] imm;
  } atom_t;

  typedef struct packed {
    logic  vld;
    atom_t atom;
  } issue_t;

  // unit fed by a slot in the four-slot format
  function automatic logic [UNIT_W-1:0] long_unit(input int slot);
    case (slot)
      0:       return UNIT_INT0;
      1:       return UNIT_FPU;
      2:       return UNIT_LSU;
      default: return UNIT_BRU;
    endcase
  endfunction

  // unit fed by a slot in the two-slot format
  function automatic logic [UNIT_W-1:0] short_unit(input int slot);
    return (slot == 0) ? UNIT_INT0 : UNIT_INT1;
  endfunction
endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import vliw_pkg::*;
(
  input  atom_t  raw_i,
  input  logic   present_i,
  output issue_t slot_o
);
  logic live;

  assign live = present_i && (raw_i.op != '0);

  always_comb begin
    slot_o.vld  = live;
    slot_o.atom = live ? raw_i : '0;
  end
endmodule

// File: rtl/slot_router.sv
module slot_router
  import vliw_pkg::*;
(
  input  issue_t slots_i [MAX_SLOTS],
  input  logic   is_long_i,
  output issue_t units_o [NUM_UNITS]
);
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) units_o[u] = '0;
    for (int s = 0; s < MAX_SLOTS; s++) begin
      if (is_long_i)
        units_o[long_unit(s)] = slots_i[s];
      else if (s < SHORT_SLOTS)
        units_o[short_unit(s)] = slots_i[s];
    end
  end
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vliw_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stall,
  input  logic                       mol_vld,
  input  logic [MOL_W-1:0]           mol_data,
  output logic                       issue_long,
  output logic [NUM_UNITS-1:0]       u_vld,
  output logic [NUM_UNITS*OP_W-1:0]  u_op,
  output logic [NUM_UNITS-1:0]       u_cc,
  output logic [NUM_UNITS*REG_W-1:0] u_dst,
  output logic [NUM_UNITS*REG_W-1:0] u_sa,
  output logic [NUM_UNITS*REG_W-1:0] u_sb,
  output logic [NUM_UNITS*IMM_W-1:0] u_imm
);
  issue_t slot_dec [MAX_SLOTS];
  issue_t unit_nxt [NUM_UNITS];
  issue_t unit_q   [NUM_UNITS];
  logic   is_long;
  logic   long_q;

  assign is_long = mol_data[FMT_BIT];

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    atom_decode u_dec (
      .raw_i     (atom_t'(mol_data[s*ATOM_W +: ATOM_W])),
      .present_i (is_long || (s < SHORT_SLOTS)),
      .slot_o    (slot_dec[s])
    );
  end

  slot_router u_route (
    .slots_i   (slot_dec),
    .is_long_i (is_long),
    .units_o   (unit_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < NUM_UNITS; u++) unit_q[u] <= '0;
      long_q <= 1'b0;
    end else if (!stall) begin
      for (int u = 0; u < NUM_UNITS; u++)
        unit_q[u] <= mol_vld ? unit_nxt[u] : '0;
      long_q <= mol_vld && is_long;
    end
  end

  assign issue_long = long_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_out
    assign u_vld[u]                 = unit_q[u].vld;
    assign u_op[u*OP_W +: OP_W]     = unit_q[u].atom.op;
    assign u_cc[u]                  = unit_q[u].atom.cc;
    assign u_dst[u*REG_W +: REG_W]  = unit_q[u].atom.dst;
    assign u_sa[u*REG_W +: REG_W]   = unit_q[u].atom.sa;
    assign u_sb[u*REG_W +: REG_W]   = unit_q[u].atom.sb;
    assign u_imm[u*IMM_W +: IMM_W]  = unit_q[u].atom.imm;

    // R5
    idle_unit_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !u_vld[u] |-> (u_op[u*OP_W +: OP_W] == '0 && !u_cc[u]
                     && u_dst[u*REG_W +: REG_W] == '0));
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(u_vld) && $stable(u_op) && $stable(u_dst) && $stable(issue_long)));

  // R10
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !mol_vld) |=> (u_vld == '0 && !issue_long));

  // R3
  long_no_int1_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && mol_vld && mol_data[FMT_BIT]) |=> !u_vld[UNIT_INT1]);

  // R4
  short_no_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && mol_vld && !mol_data[FMT_BIT]) |=>
      (!u_vld[UNIT_FPU] && !u_vld[UNIT_LSU] && !u_vld[UNIT_BRU]));

  // R2
  fmt_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && mol_vld) |=> (issue_long == $past(mol_data[FMT_BIT])));
endmodule

// File: tb/test_vliw_dispatch.sv
module test_vliw_dispatch;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stall = 1'b0;
  logic         mol_vld = 1'b0;
  logic [127:0] mol_data = '0;
  logic         issue_long;
  logic [4:0]   u_vld, u_cc;
  logic [29:0]  u_op, u_dst, u_sa, u_sb;
  logic [34:0]  u_imm;

  logic         exp_long;
  logic [4:0]   exp_vld, exp_cc;
  logic [29:0]  exp_op, exp_dst, exp_sa, exp_sb;
  logic [34:0]  exp_imm;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_dispatch i_vliw_dispatch (
    .clk(clk), .rst(rst), .stall(stall), .mol_vld(mol_vld), .mol_data(mol_data),
    .issue_long(issue_long), .u_vld(u_vld), .u_op(u_op), .u_cc(u_cc),
    .u_dst(u_dst), .u_sa(u_sa), .u_sb(u_sb), .u_imm(u_imm)
  );

  task automatic clear_exp();
    exp_long = 1'b0; exp_vld = '0; exp_cc = '0;
    exp_op = '0; exp_dst = '0; exp_sa = '0; exp_sb = '0; exp_imm = '0;
  endtask

  // model of R2..R7: slot k sits at bits 32k+31:32k
  task automatic model(input logic [127:0] m);
    int unit;
    logic [31:0] a;
    clear_exp();
    exp_long = m[0];
    for (int k = 0; k < (m[0] ? 4 : 2); k++) begin
      a = m[32*k +: 32];
      unit = m[0] ? ((k == 0) ? 0 : k + 1) : k;
      if (a[31:26] != 6'd0) begin
        exp_vld[unit]        = 1'b1;
        exp_op[unit*6 +: 6]  = a[31:26];
        exp_cc[unit]         = a[25];
        exp_dst[unit*6 +: 6] = a[24:19];
        exp_sa[unit*6 +: 6]  = a[18:13];
        exp_sb[unit*6 +: 6]  = a[12:7];
        exp_imm[unit*7 +: 7] = a[6:0];
      end
    end
  endtask

  task automatic compare(input string req);
    logic [194:0] act, exp;
    act = {issue_long, u_vld, u_op, u_cc, u_dst, u_sa, u_sb, u_imm};
    exp = {exp_long, exp_vld, exp_op, exp_cc, exp_dst, exp_sa, exp_sb, exp_imm};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic v, input logic [127:0] d, input logic s, input string req);
    mol_vld = v; mol_data = d; stall = s;
    @(posedge clk);
    if (!s) begin
      if (v) model(d);
      else clear_exp();
    end
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [31:0] mk_atom(input logic [5:0] op, input logic cc,
      input logic [5:0] d, input logic [5:0] a, input logic [5:0] b, input logic [6:0] imm);
    return {op, cc, d, a, b, imm};
  endfunction

  function automatic logic [127:0] rand_mol(input logic fmt);
    logic [127:0] m;
    for (int k = 0; k < 4; k++) begin
      m[32*k +: 32] = $urandom;
      if (($urandom % 4) == 0) m[32*k+26 +: 6] = 6'd0;
    end
    m[0] = fmt;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] m;
    void'($urandom(32'd1234));
    clear_exp();
    // R1: inputs busy during reset
    mol_vld = 1'b1; mol_data = {4{32'hFFFF_FFFF}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;

    // R3 R6 R7: full long molecule
    m = {mk_atom(6'h11, 1'b1, 6'd63, 6'd1, 6'd2, 7'h7F),
         mk_atom(6'h22, 1'b0, 6'd5, 6'd6, 6'd7, 7'h15),
         mk_atom(6'h3F, 1'b1, 6'd0, 6'd62, 6'd31, 7'h2A),
         mk_atom(6'h01, 1'b0, 6'd10, 6'd20, 6'd30, 7'h01)};
    step(1'b1, m, 1'b0, "R3 long routing");
    compare("R6 field extraction");
    compare("R7 condition-code flag");

    // R2 R4: short, upper half full of live-looking atoms
    m[63:0] = {mk_atom(6'h05, 1'b1, 6'd9, 6'd8, 6'd7, 7'h04),
               mk_atom(6'h07, 1'b0, 6'd3, 6'd4, 6'd5, 7'h02)};
    m[127:64] = {2{mk_atom(6'h3F, 1'b1, 6'd63, 6'd63, 6'd63, 7'h7F)}};
    step(1'b1, m, 1'b0, "R4 short routing");
    compare("R2 upper half ignored");

    // R5: no-op slots in long format
    m = {mk_atom(6'h00, 1'b1, 6'd1, 6'd1, 6'd1, 7'h7F),
         mk_atom(6'h09, 1'b1, 6'd2, 6'd3, 6'd4, 7'h00),
         mk_atom(6'h00, 1'b1, 6'd5, 6'd5, 6'd5, 7'h55),
         mk_atom(6'h0A, 1'b0, 6'd6, 6'd7, 6'd8, 7'h01)};
    step(1'b1, m, 1'b0, "R5 no-op slots");

    // R9: stall with a different molecule presented
    step(1'b1, rand_mol(1'b0), 1'b1, "R9 stall holds");
    step(1'b1, rand_mol(1'b1), 1'b1, "R9 stall drops input");

    // R10: bubble
    step(1'b0, rand_mol(1'b1), 1'b0, "R10 bubble");

    // R8: back-to-back molecules in order
    for (int i = 0; i < 4; i++) step(1'b1, rand_mol(i[0]), 1'b0, "R8 in-order issue");

    // R2: all-zero short molecule
    step(1'b1, 128'd0, 1'b0, "R2 empty short");

    // random mix
    for (int i = 0; i < 500; i++)
      step(($urandom % 5) != 0, rand_mol($urandom % 2), ($urandom % 5) == 0, "R8 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule